// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Unit

This block keeps the status byte of a serial flash slave and decides, for each command that would modify the device, whether that command may run. A command decoder in front of it turns finished serial frames into one-cycle strobes: write-enable, write-disable, status write (with its data byte), page program, block erase and chip erase. The array block index and the active-low write-protect pin come along with these strobes. For every modifying strobe the unit raises exactly one flag, accept or reject. An accepted command starts a self-timed busy period. Its length in clock cycles is set at a port, and it stands in for the internal program, erase or status-write cycle.

Two block-protect bits select the protection level. The map is not monotonic. With both bits at 0, nothing is protected. With exactly one bit set, program and erase are still allowed on every block but chip erase is refused. With both bits set, every block is closed to program, block erase and chip erase. A status-lock bit works together with the write-protect pin to freeze the status bits in hardware. Serial shifting and array storage belong to other blocks.

Top module: `flash_sr_guard`

## Requirements
- R1: The status byte reads {lock, 0, 0, 0, prot_hi, prot_lo, wel, busy}, with bit 7 = lock, bits 3:2 = protect bits, bit 1 = write-enable latch (wel) and bit 0 = busy. Bits 6:4 always read 0. The first cycle after a synchronous reset reads 00h, and both flag vectors read 0 in that cycle.
- R2: An accepted status write copies data bits 7, 3 and 2 into the lock and protect bits. It leaves wel and busy unaffected by its data byte.
- R3: A status write, page program, block erase or chip erase is rejected when wel is 0.
- R4: Write-enable sets wel and write-disable clears it. A rejected command leaves wel unchanged.
- R5: A status write is rejected while lock = 1 and wp_n = 0, whichever of the two became true last. It becomes writable again when wp_n returns to 1.
- R6: Page program and block erase on any block are rejected when the protect bits are 11. They are not rejected for the values 00, 01 or 10.
- R7: Chip erase is accepted only when both protect bits are 0.
- R8: Flags are registered and pulse for one cycle, the cycle after the strobe. acc_o and rej_o use bit 0 for status write, bit 1 for page program, bit 2 for block erase and bit 3 for chip erase. An acceptance raises busy in the same cycle as the flag. Busy then stays 1 for max(cycle_len, 2) cycles.
- R9: While busy is 1, every strobe is ignored: no flag is raised and no status bit changes.
- R10: wel returns to 0 at the end of each accepted operation. It is already 0 in the last cycle in which busy is 1.
- R11: When several strobes arrive in one cycle, only one is acted on. The priority is status write, then page program, block erase, chip erase, write-enable, write-disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| wrsr_data | input | 8 | Data byte of the status write |
| cmd_pp | input | 1 | Page program strobe |
| cmd_be | input | 1 | Block erase strobe |
| cmd_ce | input | 1 | Chip erase strobe |
| blk_sel | input | BLK_W | Target block of program or block erase |
| wp_n | input | 1 | Write-protect pin, active low |
| cycle_len | input | CNT_W | Busy period length in cycles |
| status_q | output | 8 | Status byte for readout |
| acc_o | output | 4 | Accept pulses per modifying command |
| rej_o | output | 4 | Reject pulses per modifying command |

## Verification
The main check is a sweep over every combination of protect bits, lock bit, pin level, latch state, command and target block. Each combination is compared with a model in the bench. This sweep separates the non-monotonic protect map (01 and 10 against 00 and 11) from the pin-and-lock freeze, and both from the plain latch gate. Status writes carry junk in the bits they must not change, so a write that leaks into bits 6:4 or 1:0 shows up. Directed sequences measure the busy length, including the clamp at short lengths, and the cycle in which wel drops. They also fire strobes mid-cycle to show that they have no effect. Finally, simultaneous strobes are used to expose the priority order.

// File: rtl/flash_sr_pkg.sv
// Package: shared bit positions and operation codes for the flash
// status/protection unit. Assumes an 8-bit status byte.
package flash_sr_pkg;
    localparam int SR_LOCK = 7;
    localparam int SR_PHI  = 3;
    localparam int SR_PLO  = 2;
    localparam int SR_WEL  = 1;
    localparam int SR_BUSY = 0;

    // Index of each modifying command inside the flag vectors
    localparam int F_WRSR = 0;
    localparam int F_PROG = 1;
    localparam int F_BERS = 2;
    localparam int F_CERS = 3;
    localparam int N_FLAG = 4;

    typedef enum logic [2:0] {
        OP_NONE, OP_WRSR, OP_PROG, OP_BERS, OP_CERS, OP_WREN, OP_WRDI
    } sr_op_e;

    typedef struct packed {
        logic cers;
        logic bers;
        logic prog;
        logic wrsr;
    } op_ok_t;
endpackage

// File: rtl/fsr_prot_eval.sv
// Module: combinational permission check for every modifying command.
// Assumes the inputs are the current registered status bits; it holds no
// state. Each block gets its own lock flag from a generate loop, so a map
// that differs per block changes only here.
module fsr_prot_eval
    import flash_sr_pkg::*;
#(
    parameter int N_BLK = 2,
    parameter int BLK_W = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
    input  logic             wel,
    input  logic [1:0]       prot,
    input  logic             lock,
    input  logic             wp_n,
    input  logic [BLK_W-1:0] blk_sel,
    output op_ok_t           ok
);
    logic [N_BLK-1:0] blk_locked;
    logic             tgt_locked;

    // Per-block lock: only the "both bits set" level closes a block
    generate
        for (genvar b = 0; b < N_BLK; b++) begin : g_blk
            assign blk_locked[b] = (prot == 2'b11);
        end
    endgenerate

    // Select the lock of the addressed block; out-of-range counts as locked
    always_comb begin
        tgt_locked = 1'b1;
        for (int b = 0; b < N_BLK; b++) begin
            if (blk_sel == BLK_W'(b)) tgt_locked = blk_locked[b];
        end
    end

    // Combine latch, hardware lock and protect level into permissions
    always_comb begin
        ok.wrsr = wel && !(lock && !wp_n);
        ok.prog = wel && !tgt_locked;
        ok.bers = wel && !tgt_locked;
        ok.cers = wel && (prot == 2'b00);
    end
endmodule

// File: rtl/fsr_busy_timer.sv
// Module: self-timed cycle model. A start pulse loads max(len, 2) and busy
// stays high that many cycles. wel_drop marks the next-to-last busy cycle
// so the latch can clear before busy falls. Assumes start is ignored
// while busy.
module fsr_busy_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             busy,
    output logic             wel_drop
);
    localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);

    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] eff_len;

    // Clamp short lengths so the latch-clear cycle always exists
    assign eff_len = (len < MIN_LEN) ? MIN_LEN : len;

    // Load, count down and end the busy window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            busy   <= 1'b0;
        end else if (start && !busy) begin
            remain <= eff_len;
            busy   <= 1'b1;
        end else if (busy) begin
            remain <= remain - CNT_W'(1);
            if (remain == CNT_W'(1)) busy <= 1'b0;
        end
    end

    assign wel_drop = busy && (remain == MIN_LEN);
endmodule

// File: rtl/flash_sr_guard.sv
// Module: status register and write-protect arbiter for a serial flash
// slave. Takes one-cycle command strobes from a decoder and produces
// registered accept/reject pulses, the status byte and a busy window.
// Assumes strobes are synchronous to clk; simultaneous strobes resolve by
// fixed priority.
module flash_sr_guard
    import flash_sr_pkg::*;
#(
    parameter int N_BLK = 2,
    parameter int BLK_W = (N_BLK > 1) ? $clog2(N_BLK) : 1,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wren,
    input  logic             cmd_wrdi,
    input  logic             cmd_wrsr,
    input  logic [7:0]       wrsr_data,
    input  logic             cmd_pp,
    input  logic             cmd_be,
    input  logic             cmd_ce,
    input  logic [BLK_W-1:0] blk_sel,
    input  logic             wp_n,
    input  logic [CNT_W-1:0] cycle_len,
    output logic [7:0]       status_q,
    output logic [3:0]       acc_o,
    output logic [3:0]       rej_o
);
    logic        lock_q;
    logic [1:0]  prot_q;
    logic        wel_q;
    logic        busy;
    logic        wel_drop;
    logic        start;
    op_ok_t      ok;
    sr_op_e      op_sel;
    logic        op_modify;
    logic        op_allowed;
    logic [N_FLAG-1:0] op_bit;

    fsr_prot_eval #(.N_BLK(N_BLK), .BLK_W(BLK_W)) u_eval (
        .wel     (wel_q),
        .prot    (prot_q),
        .lock    (lock_q),
        .wp_n    (wp_n),
        .blk_sel (blk_sel),
        .ok      (ok)
    );

    fsr_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .len      (cycle_len),
        .busy     (busy),
        .wel_drop (wel_drop)
    );

    // Pick one strobe by fixed priority; nothing is taken while busy
    always_comb begin
        op_sel = OP_NONE;
        if (!busy) begin
            if      (cmd_wrsr) op_sel = OP_WRSR;
            else if (cmd_pp)   op_sel = OP_PROG;
            else if (cmd_be)   op_sel = OP_BERS;
            else if (cmd_ce)   op_sel = OP_CERS;
            else if (cmd_wren) op_sel = OP_WREN;
            else if (cmd_wrdi) op_sel = OP_WRDI;
        end
    end

    // Map the chosen operation to its flag bit and its permission
    always_comb begin
        op_bit     = '0;
        op_allowed = 1'b0;
        op_modify  = 1'b1;
        unique case (op_sel)
            OP_WRSR: begin op_bit[F_WRSR] = 1'b1; op_allowed = ok.wrsr; end
            OP_PROG: begin op_bit[F_PROG] = 1'b1; op_allowed = ok.prog; end
            OP_BERS: begin op_bit[F_BERS] = 1'b1; op_allowed = ok.bers; end
            OP_CERS: begin op_bit[F_CERS] = 1'b1; op_allowed = ok.cers; end
            default: op_modify = 1'b0;
        endcase
    end

    assign start = op_modify && op_allowed;

    // Register one-cycle accept/reject pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o <= '0;
            rej_o <= '0;
        end else begin
            acc_o <= start ? op_bit : '0;
            rej_o <= (op_modify && !op_allowed) ? op_bit : '0;
        end
    end

    // Write-enable latch: set/clear by command, dropped near cycle end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q <= 1'b0;
        end else if (wel_drop) begin
            wel_q <= 1'b0;
        end else if (op_sel == OP_WREN) begin
            wel_q <= 1'b1;
        end else if (op_sel == OP_WRDI) begin
            wel_q <= 1'b0;
        end
    end

    // Non-volatile-style bits: only an accepted status write changes them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            prot_q <= 2'b00;
        end else if (start && op_sel == OP_WRSR) begin
            lock_q <= wrsr_data[SR_LOCK];
            prot_q <= {wrsr_data[SR_PHI], wrsr_data[SR_PLO]};
        end
    end

    assign status_q = {lock_q, 3'b000, prot_q, wel_q, busy};
endmodule

// File: rtl/flash_sr_guard_chk.sv
// Module: property checker for flash_sr_guard, bound to every instance.
// Observes ports only; assumes synchronous active-low reset.
module flash_sr_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wren,
    input logic       cmd_wrdi,
    input logic       cmd_wrsr,
    input logic       cmd_pp,
    input logic       cmd_be,
    input logic       cmd_ce,
    input logic       wp_n,
    input logic [7:0] status_q,
    input logic [3:0] acc_o,
    input logic [3:0] rej_o
);
    logic any_cmd;
    assign any_cmd = cmd_wren | cmd_wrdi | cmd_wrsr | cmd_pp | cmd_be | cmd_ce;

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (status_q == 8'h00));

    p_pad_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[6:4] == 3'b000);

    p_accept_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|acc_o) |-> $past(status_q[1]));

    p_hw_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && !status_q[0] && status_q[7] && !wp_n) |=> !acc_o[0]);

    p_chip_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o[3] |-> ($past(status_q[3:2]) == 2'b00));

    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|acc_o) |-> status_q[0]);

    p_one_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_o, rej_o}));

    p_busy_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[0] && any_cmd) |=> ((acc_o == 4'h0) && (rej_o == 4'h0)));

    p_wel_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_q[0]) |-> !$past(status_q[1]));
endmodule

bind flash_sr_guard flash_sr_guard_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wren (cmd_wren),
    .cmd_wrdi (cmd_wrdi),
    .cmd_wrsr (cmd_wrsr),
    .cmd_pp   (cmd_pp),
    .cmd_be   (cmd_be),
    .cmd_ce   (cmd_ce),
    .wp_n     (wp_n),
    .status_q (status_q),
    .acc_o    (acc_o),
    .rej_o    (rej_o)
);

// File: tb/flash_sr_guard_test.sv
// Bench: full sweep of protection state x command x block plus directed
// timing, busy and priority sequences. Drives and samples on falling edges.
module flash_sr_guard_test;
    localparam int CNT_W = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_be, cmd_ce;
    logic [7:0]  wrsr_data;
    logic [0:0]  blk_sel;
    logic        wp_n;
    logic [CNT_W-1:0] cycle_len;
    logic [7:0]  status_q;
    logic [3:0]  acc_o, rej_o;

    int checks = 0;
    int fails  = 0;
    logic [3:0] got_acc, got_rej;

    // model state
    logic m_lock, m_wel;
    logic [1:0] m_prot;

    always #2 clk = ~clk;

    flash_sr_guard #(.N_BLK(2), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
        .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .cmd_pp(cmd_pp),
        .cmd_be(cmd_be), .cmd_ce(cmd_ce), .blk_sel(blk_sel), .wp_n(wp_n),
        .cycle_len(cycle_len), .status_q(status_q), .acc_o(acc_o), .rej_o(rej_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // op: 0 wrsr, 1 pp, 2 be, 3 ce, 4 wren, 5 wrdi
    task automatic strobe(input int op, input logic [7:0] d, input logic b);
        wrsr_data = d;
        blk_sel   = b;
        cmd_wrsr  = (op == 0);
        cmd_pp    = (op == 1);
        cmd_be    = (op == 2);
        cmd_ce    = (op == 3);
        cmd_wren  = (op == 4);
        cmd_wrdi  = (op == 5);
        @(negedge clk);
        got_acc = acc_o;
        got_rej = rej_o;
        {cmd_wrsr, cmd_pp, cmd_be, cmd_ce, cmd_wren, cmd_wrdi} = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && status_q[0]; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] model_sr();
        return {m_lock, 3'b000, m_prot, m_wel, 1'b0};
    endfunction

    function automatic bit model_ok(input int op);
        if (!m_wel) return 1'b0;
        case (op)
            0:       return !(m_lock && !wp_n);
            1, 2:    return m_prot != 2'b11;
            default: return m_prot == 2'b00;
        endcase
    endfunction

    // Watchdog: a hang counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hang expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        {cmd_wrsr, cmd_pp, cmd_be, cmd_ce, cmd_wren, cmd_wrdi} = '0;
        wrsr_data = '0; blk_sel = '0; wp_n = 1'b1; cycle_len = CNT_W'(3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(status_q == 8'h00, "R1 reset status", status_q, 0);
        chk(acc_o == 0 && rej_o == 0, "R1 reset flags", {acc_o, rej_o}, 0);

        // R4: latch set and clear; rejected command keeps latch
        strobe(4, 0, 0);
        chk(status_q == 8'h02, "R4 wren", status_q, 8'h02);
        strobe(5, 0, 0);
        chk(status_q == 8'h00, "R4 wrdi", status_q, 8'h00);
        strobe(1, 0, 0);
        chk(got_rej == 4'b0010 && got_acc == 0, "R3 pp without wel", got_rej, 4'b0010);

        // Main sweep over protect, lock, pin, latch, command, block
        for (int bp = 0; bp < 4; bp++)
        for (int lk = 0; lk < 2; lk++)
        for (int wp = 0; wp < 2; wp++)
        for (int we = 0; we < 2; we++)
        for (int op = 0; op < 4; op++)
        for (int bk = 0; bk < 2; bk++) begin
            string tag;
            bit    exp_ok;
            logic [7:0] nd;
            wp_n = 1'b1;
            strobe(4, 0, 0);
            strobe(0, {lk[0], 3'b101, bp[1:0], 2'b11}, 0);
            wait_idle();
            m_lock = lk[0]; m_prot = bp[1:0]; m_wel = 1'b0;
            chk(status_q == model_sr(), "R2 status setup", status_q, model_sr());
            if (we != 0) begin
                strobe(4, 0, 0);
                m_wel = 1'b1;
            end
            wp_n = wp[0];
            @(negedge clk);
            exp_ok = model_ok(op);
            if (!m_wel) tag = "R3 latch gate";
            else if (op == 0) tag = "R5 status lock";
            else if (op == 3) tag = "R7 chip erase";
            else tag = "R6 block protect";
            nd = {~lk[0], 3'b110, ~bp[1:0], 2'b01};
            strobe(op, nd, bk[0]);
            chk(got_acc == (exp_ok ? 4'(1 << op) : 4'h0), {tag, " acc"}, got_acc,
                exp_ok ? (1 << op) : 0);
            chk(got_rej == (exp_ok ? 4'h0 : 4'(1 << op)), {tag, " rej"}, got_rej,
                exp_ok ? 0 : (1 << op));
            wait_idle();
            if (exp_ok) begin
                m_wel = 1'b0;
                if (op == 0) begin m_lock = nd[7]; m_prot = nd[3:2]; end
            end
            chk(status_q == model_sr(), "R2 status after", status_q, model_sr());
        end
        wp_n = 1'b1;

        // Clear protection for timing tests
        strobe(4, 0, 0);
        strobe(0, 8'h00, 0);
        wait_idle();

        // R8/R10: busy length and latch drop for several lengths
        for (int ln = 0; ln < 7; ln++) begin
            int n;
            int exp_len;
            logic wel_last, wel_prev;
            cycle_len = CNT_W'(ln);
            exp_len = (ln < 2) ? 2 : ln;
            strobe(4, 0, 0);
            strobe(1, 0, 0);
            chk(got_acc == 4'b0010, "R8 pp accepted", got_acc, 4'b0010);
            n = 0; wel_last = 1'b1; wel_prev = 1'b1;
            while (status_q[0] && n < 50) begin
                wel_prev = wel_last;
                wel_last = status_q[1];
                n++;
                @(negedge clk);
            end
            chk(n == exp_len, "R8 busy length", n, exp_len);
            chk(wel_last == 1'b0, "R10 wel cleared before idle", wel_last, 0);
            chk(wel_prev == 1'b1, "R10 wel drop cycle", wel_prev, 1);
        end

        // R9: strobes during busy have no effect
        cycle_len = CNT_W'(12);
        strobe(4, 0, 0);
        strobe(2, 0, 1);
        chk(got_acc == 4'b0100, "R9 be accepted", got_acc, 4'b0100);
        strobe(5, 0, 0);
        chk(got_acc == 0 && got_rej == 0 && status_q == 8'h03, "R9 wrdi ignored",
            status_q, 8'h03);
        strobe(0, 8'h8C, 0);
        chk(got_acc == 0 && got_rej == 0, "R9 wrsr ignored flags", {got_acc, got_rej}, 0);
        strobe(3, 0, 0);
        chk(got_acc == 0 && got_rej == 0, "R9 ce ignored flags", {got_acc, got_rej}, 0);
        wait_idle();
        chk(status_q == 8'h00, "R9 status untouched", status_q, 8'h00);
        strobe(4, 0, 0);
        wait_idle();
        strobe(5, 0, 0);

        // R11: simultaneous strobes resolved by priority
        cycle_len = CNT_W'(3);
        strobe(4, 0, 0);
        cmd_pp = 1'b1; cmd_ce = 1'b1; cmd_wrdi = 1'b1;
        @(negedge clk);
        got_acc = acc_o;
        {cmd_pp, cmd_ce, cmd_wrdi} = '0;
        chk(got_acc == 4'b0010, "R11 pp over ce and wrdi", got_acc, 4'b0010);
        wait_idle();
        cmd_wren = 1'b1; cmd_wrdi = 1'b1;
        @(negedge clk);
        {cmd_wren, cmd_wrdi} = '0;
        chk(status_q == 8'h02, "R11 wren over wrdi", status_q, 8'h02);
        cmd_wrsr = 1'b1; wrsr_data = 8'h0C; cmd_be = 1'b1;
        @(negedge clk);
        got_acc = acc_o;
        {cmd_wrsr, cmd_be} = '0;
        chk(got_acc == 4'b0001, "R11 wrsr over be", got_acc, 4'b0001);
        wait_idle();
        chk(status_q == 8'h0C, "R11 status written", status_q, 8'h0C);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule